// File: doc/BRIEF.md
# Receive Queue with Line Status Reporting

This block sits between a UART receiver and a CPU. The receiver hands over one finished character per cycle on a push strobe. Each character comes with three tags: parity error, framing error and break. The block keeps the characters in order and shows the oldest one to the CPU. The CPU takes that character with a pop strobe. A separate status-read strobe reads an 8-bit line status word, which gathers receive conditions and two transmitter conditions.

Two modes are chosen by `fifoMode`. With `fifoMode` = 1, a queue of `DEPTH` entries (16 by default) is used, and each entry stores its own error tags. A tag shows in the status word only once its character is the oldest one held. With `fifoMode` = 0, a single holding register is used, and a newer character replaces an unread one. The mode is expected to change only while nothing is held. The transmitter bits come straight from the two transmit-side empty inputs.

Status word bits: bit0 data ready, bit1 overrun, bit2 parity error, bit3 framing error, bit4 break, bit5 transmit holding/FIFO empty, bit6 transmitter fully empty, bit7 queued-error summary.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset, status bits 0, 1, 2, 3, 4 and 7 read 0.
- R2: Bit0 is 1 while at least one character is held and returns to 0 only after every held character has been popped. In FIFO mode, up to 16 characters are delivered on `rxData` in arrival order.
- R3: In FIFO mode, a push while 16 characters are held and no pop occurs in the same cycle drops the new character, sets bit1, and leaves the held characters unchanged.
- R4: Overrun shows in bit1 in the cycle after it occurs, whatever the tags of the character at the head.
- R5: The parity, framing and break tags of a character (bits 2, 3, 4) are latched into the status word when that character becomes the oldest held one, and not before.
- R6: A status read clears bits 1 to 4 at the next clock edge. A new setting of a bit in the same cycle as the read wins, and the bit stays 1.
- R7: In FIFO mode, bit7 is 1 while any held character has an error tag. Once it is set, only a status read made while no tagged character remains clears it.
- R8: In non-FIFO mode, bit7 reads 0.
- R9: In non-FIFO mode, a push while a character is held and not being popped replaces that character and sets bit1.
- R10: Bit5 equals `txFifoEmpty`. Bit6 equals `txFifoEmpty` AND `txShiftEmpty`.
- R11: A pop while nothing is held has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoMode | input | 1 | 1 selects the queue, 0 selects the single holding register |
| pushValid | input | 1 | One-cycle strobe: a received character is offered |
| pushData | input | 8 | Received character |
| pushParityErr | input | 1 | Parity error tag of the offered character |
| pushFrameErr | input | 1 | Framing error tag of the offered character |
| pushBreak | input | 1 | Break tag of the offered character |
| popRd | input | 1 | CPU strobe that removes the oldest character |
| statusRd | input | 1 | CPU strobe that reads the status word |
| txFifoEmpty | input | 1 | Transmit holding register or transmit FIFO is empty |
| txShiftEmpty | input | 1 | Transmit shift register is empty |
| rxData | output | 8 | Oldest held character |
| lineStatus | output | 8 | Line status word |

## Verification
The queue is driven with clean bursts to check arrival order. A mixed run follows, with clean, parity-tagged and framing-tagged characters, which separates head-only latching from immediate reporting and from the queue-wide summary. A fill to capacity plus one more push shows the difference between dropping a character (FIFO mode) and replacing one (holding-register mode). The same full state, with a status read in the cycle of the overflow, checks that the set wins over the clear. Pops while empty and all four transmit-input combinations cover the remaining corners.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rxEntry_t;

  typedef struct packed {
    logic wrEn;      // store the pushed entry
    logic wrAtHead;  // store it over the head instead of at the tail
    logic rdEn;      // advance past the head
  } qStrobe_t;

  function automatic logic hasErr(input rxEntry_t e);
    return e.brk | e.frm | e.par;
  endfunction
endpackage

// File: rtl/rx_status_store.sv
module rx_status_store
  import rsf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  qStrobe_t strobe,
  input  rxEntry_t wrEntry,
  output rxEntry_t headEntry,
  output rxEntry_t nextEntry
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  rxEntry_t mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, wrPtrInc, rdPtrInc, wrAddr;

  always_comb begin
    wrPtrInc = (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
    rdPtrInc = (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
    wrAddr   = strobe.wrAtHead ? rdPtr : wrPtr;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrAddr] <= wrEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.wrEn && !strobe.wrAtHead) wrPtr <= wrPtrInc;
      if (strobe.rdEn) rdPtr <= rdPtrInc;
    end
  end

  assign headEntry = mem[rdPtr];
  assign nextEntry = mem[rdPtrInc];

  AST_HEAD_OVERWRITE_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrAtHead |-> (strobe.wrEn && !strobe.rdEn)); // R9
endmodule

// File: rtl/rx_status_ctrl.sv
module rx_status_ctrl
  import rsf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     fifoMode,
  input  logic     pushValid,
  input  rxEntry_t pushEntry,
  input  logic     popRd,
  input  logic     statusRd,
  input  rxEntry_t headEntry,
  input  rxEntry_t nextEntry,
  output qStrobe_t strobe,
  output logic     dataReady,
  output logic     overrun,
  output logic     parityFlag,
  output logic     frameFlag,
  output logic     breakFlag,
  output logic     errSummary
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [CNT_W-1:0] count, countNext;
  logic [CNT_W-1:0] errCnt, errCntNext;
  logic full, doPop, accept, overwrite, drop, overrunEvt;
  logic newHead;
  rxEntry_t newHeadEntry;

  always_comb begin
    full       = fifoMode ? (count == FULL_CNT) : (count != '0);
    doPop      = popRd && (count != '0);
    accept     = pushValid && (!full || doPop);
    overwrite  = pushValid && full && !doPop && !fifoMode;
    drop       = pushValid && full && !doPop && fifoMode;
    overrunEvt = overwrite || drop;

    strobe.wrEn     = accept || overwrite;
    strobe.wrAtHead = overwrite;
    strobe.rdEn     = doPop;

    countNext = count + CNT_W'(accept) - CNT_W'(doPop);

    errCntNext = errCnt
               + CNT_W'((accept || overwrite) && hasErr(pushEntry))
               - CNT_W'(doPop && hasErr(headEntry))
               - CNT_W'(overwrite && hasErr(headEntry));

    // Which character becomes the oldest one this cycle, if any.
    newHead      = 1'b0;
    newHeadEntry = pushEntry;
    if (doPop && count > ONE_CNT) begin
      newHead      = 1'b1;
      newHeadEntry = nextEntry;
    end else if (overwrite ||
                 (accept && (count == '0 || (doPop && count == ONE_CNT)))) begin
      newHead      = 1'b1;
      newHeadEntry = pushEntry;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count      <= '0;
      errCnt     <= '0;
      overrun    <= 1'b0;
      parityFlag <= 1'b0;
      frameFlag  <= 1'b0;
      breakFlag  <= 1'b0;
      errSummary <= 1'b0;
    end else begin
      count      <= countNext;
      errCnt     <= errCntNext;
      overrun    <= overrunEvt || (overrun && !statusRd);
      parityFlag <= (newHead && newHeadEntry.par) || (parityFlag && !statusRd);
      frameFlag  <= (newHead && newHeadEntry.frm) || (frameFlag && !statusRd);
      breakFlag  <= (newHead && newHeadEntry.brk) || (breakFlag && !statusRd);
      errSummary <= fifoMode && ((errCntNext != '0) || (errSummary && !statusRd));
    end
  end

  assign dataReady = (count != '0);

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT); // R2

  AST_OVR_ON_FULL_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (fifoMode && pushValid && count == FULL_CNT && !popRd) |=> overrun); // R3

  AST_OVR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !pushValid) |=> !overrun); // R6

  AST_SUMMARY_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (fifoMode && $stable(fifoMode) && errCnt != '0) |-> errSummary); // R7

  AST_HOLD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoMode && $stable(fifoMode) && $past(count) <= ONE_CNT) |-> count <= ONE_CNT); // R9
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
  import rsf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fifoMode,
  input  logic        pushValid,
  input  logic [7:0]  pushData,
  input  logic        pushParityErr,
  input  logic        pushFrameErr,
  input  logic        pushBreak,
  input  logic        popRd,
  input  logic        statusRd,
  input  logic        txFifoEmpty,
  input  logic        txShiftEmpty,
  output logic [7:0]  rxData,
  output logic [7:0]  lineStatus
);
  rxEntry_t pushEntry, headEntry, nextEntry;
  qStrobe_t strobe;
  logic dataReady, overrun, parityFlag, frameFlag, breakFlag, errSummary;

  assign pushEntry = '{brk: pushBreak, frm: pushFrameErr, par: pushParityErr, data: pushData};

  rx_status_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode),
    .pushValid(pushValid), .pushEntry(pushEntry),
    .popRd(popRd), .statusRd(statusRd),
    .headEntry(headEntry), .nextEntry(nextEntry),
    .strobe(strobe), .dataReady(dataReady), .overrun(overrun),
    .parityFlag(parityFlag), .frameFlag(frameFlag), .breakFlag(breakFlag),
    .errSummary(errSummary)
  );

  rx_status_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEntry(pushEntry),
    .headEntry(headEntry), .nextEntry(nextEntry)
  );

  assign rxData     = headEntry.data;
  assign lineStatus = {errSummary, txFifoEmpty & txShiftEmpty, txFifoEmpty,
                       breakFlag, frameFlag, parityFlag, overrun, dataReady};
endmodule

// File: tb/rx_status_fifo_bench.sv
module rx_status_fifo_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic fifoMode = 1'b1, pushValid = 1'b0, pushParityErr = 1'b0, pushFrameErr = 1'b0;
  logic pushBreak = 1'b0, popRd = 1'b0, statusRd = 1'b0;
  logic txFifoEmpty = 1'b1, txShiftEmpty = 1'b1;
  logic [7:0] pushData = '0, rxData, lineStatus;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rx_status_fifo u_rx_status_fifo (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .pushValid(pushValid),
    .pushData(pushData), .pushParityErr(pushParityErr), .pushFrameErr(pushFrameErr),
    .pushBreak(pushBreak), .popRd(popRd), .statusRd(statusRd),
    .txFifoEmpty(txFifoEmpty), .txShiftEmpty(txShiftEmpty),
    .rxData(rxData), .lineStatus(lineStatus)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One clock: drive at a falling edge, return after the next falling edge.
  task automatic step(input logic pv, input logic [7:0] d, input logic p, input logic f,
                      input logic b, input logic pop, input logic srd);
    @(negedge clk);
    pushValid = pv; pushData = d; pushParityErr = p; pushFrameErr = f; pushBreak = b;
    popRd = pop; statusRd = srd;
    @(negedge clk);
    pushValid = 0; popRd = 0; statusRd = 0; pushParityErr = 0; pushFrameErr = 0; pushBreak = 0;
  endtask

  task automatic testReset();
    chk("R1 reset status", lineStatus, 8'h60);
  endtask

  task automatic testOrder();
    for (int i = 0; i < 3; i++) step(1, 8'hA1 + 8'(i), 0, 0, 0, 0, 0);
    chk("R2 ready after pushes", lineStatus[0], 1);
    for (int i = 0; i < 3; i++) begin
      chk("R2 order", rxData, 8'hA1 + 8'(i));
      chk("R2 ready while held", lineStatus[0], 1);
      step(0, 0, 0, 0, 0, 1, 0);
    end
    chk("R2 ready cleared", lineStatus[0], 0);
  endtask

  task automatic testTags();
    step(1, 8'hC0, 0, 0, 0, 0, 0);
    step(1, 8'hC1, 1, 0, 0, 0, 0);
    step(1, 8'hC2, 0, 1, 0, 0, 0);
    chk("R5 clean head hides tags", lineStatus[4:2], 0);
    chk("R7 summary set", lineStatus[7], 1);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R5 parity at head", lineStatus[4:2], 3'b001);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R6 parity cleared", lineStatus[2], 0);
    chk("R7 summary kept while errors held", lineStatus[7], 1);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R5 framing at head", lineStatus[4:2], 3'b010);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R7 summary latched after drain", lineStatus[7], 1);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R7 summary cleared by read", lineStatus[7], 0);
    chk("R6 framing cleared", lineStatus[3], 0);
    step(1, 8'h00, 0, 0, 1, 0, 0);
    chk("R5 break at head", lineStatus[4:2], 3'b100);
    step(0, 0, 0, 0, 0, 1, 1);
    chk("R6 break cleared", lineStatus, 8'h60);
  endtask

  task automatic testOverrunFifo();
    for (int i = 0; i < 16; i++) step(1, 8'h10 + 8'(i), 0, 0, 0, 0, 0);
    chk("R3 no overrun at exactly full", lineStatus[1], 0);
    step(1, 8'hEE, 0, 0, 0, 0, 0);
    chk("R4 overrun reported with clean head", lineStatus[4:1], 4'b0001);
    chk("R3 head intact", rxData, 8'h10);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R6 overrun cleared", lineStatus[1], 0);
    step(1, 8'hEF, 0, 0, 0, 0, 1);
    chk("R6 set wins over read", lineStatus[1], 1);
    for (int i = 0; i < 16; i++) begin
      chk("R3 contents kept", rxData, 8'h10 + 8'(i));
      step(0, 0, 0, 0, 0, 1, 0);
    end
    chk("R2 drained", lineStatus[0], 0);
    step(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic testHolding();
    fifoMode = 0;
    step(1, 8'h55, 0, 0, 0, 0, 0);
    chk("R9 no overrun on first", lineStatus[1], 0);
    step(1, 8'h66, 1, 0, 0, 0, 0);
    chk("R9 overwrite data", rxData, 8'h66);
    chk("R9 overrun set", lineStatus[1], 1);
    chk("R8 summary zero", lineStatus[7], 0);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R9 single pop empties", lineStatus[0], 0);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R8 clean after read", lineStatus, 8'h60);
    fifoMode = 1;
  endtask

  task automatic testEmptyPop();
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R11 empty pop", lineStatus, 8'h60);
    step(1, 8'h3C, 0, 0, 0, 0, 0);
    chk("R11 data after empty pop", rxData, 8'h3C);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R11 one pop empties", lineStatus[0], 0);
  endtask

  task automatic testTx();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      txFifoEmpty = i[0]; txShiftEmpty = i[1];
      #1;
      chk("R10 tx bits", lineStatus[6:5], {i[0] & i[1], i[0]});
    end
    txFifoEmpty = 1; txShiftEmpty = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testOrder();
    testTags();
    testOverrunFifo();
    testHolding();
    testEmptyPop();
    testTx();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule